// File: doc/BRIEF.md
# Time-Multiplexed Overflow Flag Generator

This block watches two audio channels, left and right, for overrange events and reports both on one active-low, open-drain style flag line. The line is shared in time. The frame clock (LRCK) picks which channel's status the line carries, and the serial format decides which level of LRCK belongs to which channel. After each LRCK transition the line changes only at a fixed number of serial-clock periods. That delay is one SCLK period in left-justified format and two in I2S format.

An overrange makes the channel's status sticky. The status stays set until a run of frames with no new overrange on either channel has passed. Any overrange on either channel restarts that run for both channels, and at expiry both statuses clear together. The block also provides a demultiplexed pair of status outputs. It latches the line value at each LRCK transition into the channel whose interval is ending, the same way a downstream receiver would.

The design runs on a single system clock. The serial clock arrives as a one-cycle tick pulse, and LRCK arrives as a level that is sampled on that clock. The pin driver is modelled as a drive-low enable. Pull-ups and wired-OR behaviour are outside the block.

Top module: `ovf_flag_mux`

## Requirements
- R1: A synchronous active-high reset releases the line (`flag_drive_low_o` = 0), clears both sticky statuses and the frame counter, and sets both demultiplexed outputs to 0.
- R2: `flag_drive_low_o` = 1 means the line is pulled low and reports an overflow on the channel currently shown. A value of 0 releases the line.
- R3: The channel shown depends on the LRCK level and `fmt_i2s_i`. With `fmt_i2s_i` = 0 (left-justified), LRCK high shows left and LRCK low shows right. With `fmt_i2s_i` = 1 (I2S), LRCK low shows left and LRCK high shows right.
- R4: In left-justified format the line keeps its previous value after an LRCK transition. It takes the new channel's status on the first `sclk_tick_i` pulse strictly after the cycle in which the transition is seen.
- R5: In I2S format the line keeps its previous value until the second `sclk_tick_i` pulse after the LRCK transition, and updates on that pulse.
- R6: Between the update point and the next LRCK transition, the line follows the shown channel's status. An overrange pulse on that channel pulls the line low two clock cycles after the pulse cycle.
- R7: An overrange pulse that arrives during the update delay is kept, and the line shows it at the update point.
- R8: A status stays set until TIMEOUT_FRAMES rising LRCK edges have passed since the last overrange on either channel. On that edge both statuses clear together.
- R9: An overrange on either channel restarts the timeout for both channels. A pulse in the same cycle as the expiring edge cancels the expiry, and both statuses keep their values.
- R10: At each LRCK transition the line value is latched into one demultiplexed output, and that output holds its value between transitions. In left-justified format a rising LRCK edge latches the right output and a falling edge latches the left. In I2S format a rising edge latches left and a falling edge latches right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_tick_i | input | 1 | One-cycle pulse per serial-clock period |
| lrck_i | input | 1 | Frame clock level, sampled on clk |
| fmt_i2s_i | input | 1 | 0 = left-justified, 1 = I2S |
| ovr_left_i | input | 1 | Left-channel overrange pulse |
| ovr_right_i | input | 1 | Right-channel overrange pulse |
| flag_drive_low_o | output | 1 | Drive-low enable of the shared flag line |
| left_ovf_o | output | 1 | Demultiplexed left status, 1 = overflow |
| right_ovf_o | output | 1 | Demultiplexed right status, 1 = overflow |

## Verification
Two functions can land in the same cycle. The timeout can expire on a rising LRCK edge, and a fresh overrange pulse can arrive in that same cycle. The bench provokes this by timing a left pulse to the exact edge cycle on which the frame counter reaches its terminal count. The stimulus table then expects the right status to still be shown as an overflow after the next I2S update point, and it expects the statuses to clear only after a further full timeout. A second pairing places a pulse inside the I2S update delay, so the pulse's capture and the delayed update meet at the same update point.

// File: rtl/ovf_flag_pkg.sv
package ovf_flag_pkg;

  typedef enum logic {
    FMT_LJ  = 1'b0,
    FMT_I2S = 1'b1
  } frame_fmt_e;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_LEFT  = 0;
  localparam int unsigned CH_RIGHT = 1;
  localparam int unsigned DLY_W    = 2;

  // Channel carried on the line while LRCK sits at the given level.
  function automatic logic level_shows_right(input logic lvl, input frame_fmt_e fmt);
    return lvl ^ (fmt == FMT_LJ);
  endfunction

  // Serial-clock periods between an LRCK transition and the line update.
  function automatic logic [DLY_W-1:0] update_delay(input frame_fmt_e fmt);
    return (fmt == FMT_I2S) ? DLY_W'(2) : DLY_W'(1);
  endfunction

endpackage

// File: rtl/ovf_sticky_timer.sv
module ovf_sticky_timer
  import ovf_flag_pkg::*;
#(
  parameter int unsigned TIMEOUT_FRAMES = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_rise,
  input  logic [NUM_CH-1:0] ovr,
  output logic [NUM_CH-1:0] sticky
);

  localparam int unsigned CNT_W   = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_FRAMES - 1);

  logic [CNT_W-1:0] frame_cnt;
  logic             any_ovr;
  logic             any_set;
  logic             expire;

  assign any_ovr = |ovr;
  assign any_set = |sticky;
  assign expire  = frame_rise && any_set && !any_ovr && (frame_cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
    end else if (any_ovr || expire) begin
      frame_cnt <= '0;
    end else if (frame_rise && any_set) begin
      frame_cnt <= frame_cnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        sticky[g] <= 1'b0;
      end else if (ovr[g]) begin
        sticky[g] <= 1'b1;
      end else if (expire) begin
        sticky[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ovf_line_phase.sv
module ovf_line_phase
  import ovf_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_tick,
  input  logic              lrck,
  input  frame_fmt_e        fmt,
  input  logic [NUM_CH-1:0] sticky,
  output logic              lrck_prev,
  output logic              lrck_edge,
  output logic              lrck_rise,
  output logic              flag_q
);

  logic [DLY_W-1:0] pend;
  logic             live;
  logic             upd_now;
  logic             shown_bit;

  assign lrck_edge = lrck ^ lrck_prev;
  assign lrck_rise = lrck & ~lrck_prev;
  assign upd_now   = sclk_tick && (pend == DLY_W'(1));
  assign shown_bit = level_shows_right(lrck_prev, fmt) ? sticky[CH_RIGHT] : sticky[CH_LEFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_prev <= 1'b0;
      pend      <= '0;
      live      <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      lrck_prev <= lrck;
      if (lrck_edge) begin
        pend <= update_delay(fmt);
        live <= 1'b0;
      end else begin
        if (sclk_tick && (pend != '0)) begin
          pend <= pend - DLY_W'(1);
        end
        if (upd_now) begin
          live <= 1'b1;
        end
        if (live || upd_now) begin
          flag_q <= shown_bit;
        end
      end
    end
  end

endmodule

// File: rtl/ovf_status_demux.sv
module ovf_status_demux
  import ovf_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lrck_edge,
  input  logic              lrck_prev,
  input  frame_fmt_e        fmt,
  input  logic              line_val,
  output logic [NUM_CH-1:0] stat
);

  logic ending_right;

  assign ending_right = level_shows_right(lrck_prev, fmt);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lat
    localparam logic IS_RIGHT = (g == CH_RIGHT);
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[g] <= 1'b0;
      end else if (lrck_edge && (ending_right == IS_RIGHT)) begin
        stat[g] <= line_val;
      end
    end
  end

endmodule

// File: rtl/ovf_flag_mux.sv
module ovf_flag_mux
  import ovf_flag_pkg::*;
#(
  parameter int unsigned TIMEOUT_FRAMES = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_tick_i,
  input  logic lrck_i,
  input  logic fmt_i2s_i,
  input  logic ovr_left_i,
  input  logic ovr_right_i,
  output logic flag_drive_low_o,
  output logic left_ovf_o,
  output logic right_ovf_o
);

  frame_fmt_e        fmt;
  logic [NUM_CH-1:0] ovr_vec;
  logic [NUM_CH-1:0] sticky_w;
  logic [NUM_CH-1:0] stat_w;
  logic              lrck_prev_w;
  logic              lrck_edge_w;
  logic              lrck_rise_w;
  logic              flag_w;

  assign fmt                = frame_fmt_e'(fmt_i2s_i);
  assign ovr_vec[CH_LEFT]   = ovr_left_i;
  assign ovr_vec[CH_RIGHT]  = ovr_right_i;

  ovf_sticky_timer #(
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .frame_rise(lrck_rise_w),
    .ovr       (ovr_vec),
    .sticky    (sticky_w)
  );

  ovf_line_phase phase_i (
    .clk      (clk),
    .rst      (rst),
    .sclk_tick(sclk_tick_i),
    .lrck     (lrck_i),
    .fmt      (fmt),
    .sticky   (sticky_w),
    .lrck_prev(lrck_prev_w),
    .lrck_edge(lrck_edge_w),
    .lrck_rise(lrck_rise_w),
    .flag_q   (flag_w)
  );

  ovf_status_demux demux_i (
    .clk      (clk),
    .rst      (rst),
    .lrck_edge(lrck_edge_w),
    .lrck_prev(lrck_prev_w),
    .fmt      (fmt),
    .line_val (flag_w),
    .stat     (stat_w)
  );

  assign flag_drive_low_o = flag_w;
  assign left_ovf_o       = stat_w[CH_LEFT];
  assign right_ovf_o      = stat_w[CH_RIGHT];

endmodule

// File: rtl/ovf_flag_mux_chk.sv
module ovf_flag_mux_chk (
  input logic       clk,
  input logic       rst,
  input logic       lrck_i,
  input logic       ovr_left_i,
  input logic       ovr_right_i,
  input logic       flag_drive_low_o,
  input logic       left_ovf_o,
  input logic       right_ovf_o,
  input logic [1:0] sticky
);

  // R1: reset leaves the line released and the demux outputs clear
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!flag_drive_low_o && !left_ovf_o && !right_ovf_o));

  // R4: the line never moves in the cycle an LRCK transition is seen
  p_hold_at_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (lrck_i != $past(lrck_i))) |=> $stable(flag_drive_low_o));

  // R2: the line can only start pulling low when some status was set
  p_flag_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_drive_low_o) |-> $past(|sticky));

  // R8: an overrange pulse leaves its channel status set
  p_left_sticks_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_left_i |=> sticky[0]);
  p_right_sticks_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_right_i |=> sticky[1]);

  // R10: demux outputs change only after an LRCK transition
  p_demux_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (lrck_i == $past(lrck_i))) |=> ($stable(left_ovf_o) && $stable(right_ovf_o)));

endmodule

bind ovf_flag_mux ovf_flag_mux_chk chk_i (
  .clk             (clk),
  .rst             (rst),
  .lrck_i          (lrck_i),
  .ovr_left_i      (ovr_left_i),
  .ovr_right_i     (ovr_right_i),
  .flag_drive_low_o(flag_drive_low_o),
  .left_ovf_o      (left_ovf_o),
  .right_ovf_o     (right_ovf_o),
  .sticky          (sticky_w)
);

// File: tb/ovf_flag_mux_tb.sv
module ovf_flag_mux_tb_top;

  localparam int unsigned TO_FRAMES = 3;
  localparam int unsigned HALF_CYC  = 8;
  localparam int unsigned NROWS     = 25;
  localparam int unsigned WDOG      = 5000;

  typedef struct packed {
    logic       fmt;
    logic       lvl;
    logic [3:0] il;
    logic [3:0] ir;
    logic       e_early;
    logic       e_mid;
    logic       e_end;
    logic       e_dl;
    logic       e_dr;
  } vec_t;

  // one row per LRCK half-frame; il/ir = cycle of pulse, 15 = none
  localparam vec_t VECS [NROWS] = '{
    '{1'b0,1'b1,4'd15,4'd15,1'b0,1'b0,1'b0,1'b0,1'b0}, // LJ idle (R3)
    '{1'b0,1'b0,4'd4 ,4'd15,1'b0,1'b0,1'b0,1'b0,1'b0}, // left pulse, right shown
    '{1'b0,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b0,1'b0}, // left shown, LJ update (R4)
    '{1'b0,1'b0,4'd15,4'd5 ,1'b0,1'b0,1'b1,1'b1,1'b0}, // live follow (R6)
    '{1'b0,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b1,4'd15,4'd15,1'b0,1'b0,1'b0,1'b1,1'b1}, // timeout clears both (R8)
    '{1'b1,1'b0,4'd2 ,4'd15,1'b0,1'b1,1'b1,1'b1,1'b0}, // pulse in I2S delay (R7)
    '{1'b1,1'b1,4'd15,4'd7 ,1'b1,1'b0,1'b0,1'b1,1'b0}, // I2S hold then right (R5)
    '{1'b1,1'b0,4'd15,4'd15,1'b0,1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,4'd0 ,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1}, // pulse at expiry edge (R9)
    '{1'b1,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,4'd15,4'd15,1'b1,1'b0,1'b0,1'b1,1'b1}, // restarted timeout ends (R9)
    '{1'b1,1'b0,4'd15,4'd15,1'b0,1'b0,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,4'd15,4'd15,1'b0,1'b0,1'b0,1'b0,1'b0}  // demux clears (R10)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_tick_i = 1'b0;
  logic lrck_i = 1'b0;
  logic fmt_i2s_i = 1'b0;
  logic ovr_left_i = 1'b0;
  logic ovr_right_i = 1'b0;
  logic flag_drive_low_o;
  logic left_ovf_o;
  logic right_ovf_o;

  int unsigned n_total = 0;
  int unsigned n_bad = 0;

  always #2 clk = ~clk;

  ovf_flag_mux #(
    .TIMEOUT_FRAMES(TO_FRAMES)
  ) dut_i (
    .clk             (clk),
    .rst             (rst),
    .sclk_tick_i     (sclk_tick_i),
    .lrck_i          (lrck_i),
    .fmt_i2s_i       (fmt_i2s_i),
    .ovr_left_i      (ovr_left_i),
    .ovr_right_i     (ovr_right_i),
    .flag_drive_low_o(flag_drive_low_o),
    .left_ovf_o      (left_ovf_o),
    .right_ovf_o     (right_ovf_o)
  );

  task automatic chk(input string tag, input int row, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s row=%0d actual=%0b expected=%0b", tag, row, act, exp);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 reset line", -1, flag_drive_low_o, 1'b0);
    chk("R1 reset left", -1, left_ovf_o, 1'b0);
    chk("R1 reset right", -1, right_ovf_o, 1'b0);
    rst = 1'b0;

    for (int r = 0; r < int'(NROWS); r++) begin
      for (int c = 0; c < int'(HALF_CYC); c++) begin
        @(negedge clk);
        if (c == 0 && r > 0) chk("R8 R9 end of interval", r - 1, flag_drive_low_o, VECS[r-1].e_end);
        if (c == 2) chk("R4 R5 early", r, flag_drive_low_o, VECS[r].e_early);
        if (c == 6) begin
          chk("R6 R7 mid", r, flag_drive_low_o, VECS[r].e_mid);
          chk("R10 left demux", r, left_ovf_o, VECS[r].e_dl);
          chk("R10 right demux", r, right_ovf_o, VECS[r].e_dr);
        end
        fmt_i2s_i   = VECS[r].fmt;
        lrck_i      = VECS[r].lvl;
        sclk_tick_i = c[0];
        ovr_left_i  = (VECS[r].il == 4'(c));
        ovr_right_i = (VECS[r].ir == 4'(c));
      end
    end
    @(negedge clk);
    chk("R8 R9 end of interval", int'(NROWS) - 1, flag_drive_low_o, VECS[NROWS-1].e_end);

    // R6/R2: I2S, LRCK high shows right; live right pulse pulls the line
    sclk_tick_i = 1'b0;
    ovr_left_i  = 1'b1;
    ovr_right_i = 1'b1;
    @(negedge clk);
    ovr_left_i  = 1'b0;
    ovr_right_i = 1'b0;
    @(negedge clk);
    chk("R6 R2 live pull low", -2, flag_drive_low_o, 1'b1);

    // R1: reset during activity
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid reset line", -2, flag_drive_low_o, 1'b0);
    chk("R1 mid reset left", -2, left_ovf_o, 1'b0);
    chk("R1 mid reset right", -2, right_ovf_o, 1'b0);
    rst = 1'b0;
    for (int c = 0; c < int'(HALF_CYC); c++) begin
      @(negedge clk);
      sclk_tick_i = c[0];
    end
    @(negedge clk);
    chk("R1 statuses cleared by reset", -2, flag_drive_low_o, 1'b0);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule